// File: doc/BRIEF.md
# Sync-Origin Raster Timing Generator

This block produces the horizontal and vertical raster timing for one display pipe. Both pixel and line counters start from zero on the first cycle of their sync pulse. Every other position in the raster is therefore given as an offset after sync start: the sync length, the first active position, the first position after the active window, and the total period. The block drives both sync outputs with a selectable polarity, plus a data-enable signal, the raw pixel and line counts, a vertical blanking flag and a frame-start pulse. It also drives a border flag, and during the border the pixel output carries a programmable background colour.

Interlaced scan alternates two fields of equal line count. The second field has its own vertical active window. Software loads settings through a simple write port, with one 32-bit word per setting. Each timing word holds the horizontal value in its low half and the vertical value in its high half. Written values are held as pending and move into the working set only at the start of a new frame. As a result, no frame ever mixes old and new settings. A window whose end does not come after its start, or whose end is not inside the total period, produces no active video on that axis. The window never wraps.

Top module: `raster_timing_gen`

## Requirements
- R1: Under synchronous active-low reset, both counters, the field bit and all pending and working settings clear to zero. With everything at zero, de is 0, px_x and px_y stay at 0 and frame_start is 1 on every cycle.
- R2: px_x counts 0 up to H_total-1 and then wraps to 0. px_y advances when px_x wraps and itself wraps after V_total-1. A total of 0 behaves like a total of 1.
- R3: Before polarity is applied, hsync is active while px_x < H_sync and vsync is active while px_y < V_sync.
- R4: Control bit 1 inverts hsync and control bit 2 inverts vsync, making the pulse active-low.
- R5: de is 1 exactly when H_begin <= px_x < H_end and the line is inside the vertical window, which is V_begin <= px_y < V_end.
- R6: An axis whose end <= begin, or whose total <= end, has no active positions, so de stays 0.
- R7: Control bit 0 enables interlace. The field output then alternates at every vertical wrap, and during field 1 the vertical window uses field-2 word bits 31:16 as begin and bits 15:0 as end. With interlace off, field stays 0.
- R8: border is 1 when de is 0 and neither raw sync is active. pix_out equals pix_in during de, equals the background colour (red 9:0, green 19:10, blue 29:20) during border, and is 0 otherwise.
- R9: Writes go to a pending set. The working set copies the pending set on the edge where both counters wrap and the next field is 0. At all other times the working set holds.
- R10: frame_start is 1 when px_x and px_y are both 0. vblank is 1 whenever the line is outside the vertical window of the current field.
- R11: Write addresses are 0 total, 1 sync, 2 begin, 3 end, 4 field-2 window, 5 control and 6 colour. In words 0 to 3, the horizontal value sits in bits 15:0 and the vertical value in bits 31:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the setting port |
| cfg_addr | input | 3 | Setting select |
| cfg_wdata | input | 32 | Setting value |
| pix_in | input | 30 | Pixel data shown during de |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Active video |
| border | output | 1 | Background-colour region |
| vblank | output | 1 | Line outside the vertical window |
| frame_start | output | 1 | Origin of the frame or field |
| field | output | 1 | Current interlace field |
| px_x | output | 16 | Pixel count from hsync start |
| px_y | output | 16 | Line count from vsync start |
| pix_out | output | 30 | Pixel, background colour or zero |

## Verification
The bench builds the block with its default 16-bit counts and 10-bit colour channels. It programs a small raster of 12 by 8, so that each frame takes 96 cycles. This lets dozens of frames and interlaced field pairs run in a short time. It also means every register write lands at a different phase within the frame, which exercises the deferred loading of settings. The same short raster makes the degenerate windows easy to reach, covering both an empty horizontal window and a vertical end beyond the total. A change of total in mid-frame is also exercised, and it must not disturb the frame that is already running.

// File: rtl/rtg_pkg.sv
// Shared widths, setting addresses and the setting record of the
// raster timing generator. Assumes counts never exceed 16 bits, because
// each setting word carries two 16-bit halves.
package rtg_pkg;
    localparam int CW    = 16;          // count width per axis
    localparam int COL_W = 10;          // bits per colour channel
    localparam int PIX_W = 3 * COL_W;   // packed pixel width
    localparam int AW    = 3;           // setting address width
    localparam int DW    = 2 * CW;      // setting word width

    typedef enum logic [AW-1:0] {
        SEL_TOTAL  = 3'd0,
        SEL_SYNC   = 3'd1,
        SEL_BEGIN  = 3'd2,
        SEL_END    = 3'd3,
        SEL_FIELD2 = 3'd4,
        SEL_CTRL   = 3'd5,
        SEL_COLOUR = 3'd6
    } set_sel_e;

    typedef struct packed {
        logic [CW-1:0]    h_total;
        logic [CW-1:0]    v_total;
        logic [CW-1:0]    h_sync;
        logic [CW-1:0]    v_sync;
        logic [CW-1:0]    h_beg;
        logic [CW-1:0]    v_beg;
        logic [CW-1:0]    h_end;
        logic [CW-1:0]    v_end;
        logic [CW-1:0]    f2_beg;
        logic [CW-1:0]    f2_end;
        logic             ilace;
        logic             h_inv;
        logic             v_inv;
        logic [PIX_W-1:0] bg;
    } timing_set_t;
endpackage

// File: rtl/rtg_set_regs.sv
// Pending and working copies of the timing settings.
// Writes always land in the pending copy. The working copy takes the
// whole pending copy at once when 'load' is high, which the top module
// raises only at a frame origin.
module rtg_set_regs
    import rtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_sel,
    input  logic [DW-1:0]    wr_val,
    input  logic             load,
    output timing_set_t      live
);
    timing_set_t pend_q;

    // Capture writes into the pending copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (wr_en) begin
            case (set_sel_e'(wr_sel))
                SEL_TOTAL:  begin pend_q.h_total <= wr_val[CW-1:0]; pend_q.v_total <= wr_val[DW-1:CW]; end
                SEL_SYNC:   begin pend_q.h_sync  <= wr_val[CW-1:0]; pend_q.v_sync  <= wr_val[DW-1:CW]; end
                SEL_BEGIN:  begin pend_q.h_beg   <= wr_val[CW-1:0]; pend_q.v_beg   <= wr_val[DW-1:CW]; end
                SEL_END:    begin pend_q.h_end   <= wr_val[CW-1:0]; pend_q.v_end   <= wr_val[DW-1:CW]; end
                SEL_FIELD2: begin pend_q.f2_end  <= wr_val[CW-1:0]; pend_q.f2_beg  <= wr_val[DW-1:CW]; end
                SEL_CTRL:   begin
                    pend_q.ilace <= wr_val[0];
                    pend_q.h_inv <= wr_val[1];
                    pend_q.v_inv <= wr_val[2];
                end
                SEL_COLOUR: pend_q.bg <= wr_val[PIX_W-1:0];
                default:    ;
            endcase
        end
    end

    // Move the pending copy into the working copy at a frame origin.
    always_ff @(posedge clk) begin
        if (!rst_n)    live <= '0;
        else if (load) live <= pend_q;
    end

    // R9
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(live));
endmodule

// File: rtl/rtg_axis_counter.sv
// Position counter for one axis. It counts up on 'step' and returns to
// zero after reaching total-1. A total of zero is treated like a total
// of one. at_last flags the final position of the period.
module rtg_axis_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] total,
    output logic [W-1:0] count,
    output logic         at_last
);
    logic [W-1:0] last_pos;

    // Final position of the period, guarded against a zero total.
    always_comb begin
        last_pos = (total == '0) ? '0 : total - 1'b1;
        at_last  = (count >= last_pos);
    end

    // Advance or wrap the position.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (step) count <= at_last ? '0 : count + 1'b1;
    end

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !at_last) |=> (count == $past(count) + 1'b1));
    // R2
    count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_last) |=> (count == '0));
endmodule

// File: rtl/rtg_axis_window.sv
// Region decode for one axis, with all offsets measured from sync start.
// The sync region is [0, sync_len). The active window is [beg, fin),
// and it is empty unless beg < fin < total.
module rtg_axis_window #(
    parameter int W = 16
) (
    input  logic [W-1:0] count,
    input  logic [W-1:0] total,
    input  logic [W-1:0] sync_len,
    input  logic [W-1:0] beg,
    input  logic [W-1:0] fin,
    output logic         in_sync,
    output logic         in_win
);
    logic win_ok;

    // Sync region, window validity and window membership.
    always_comb begin
        in_sync = (count < sync_len);
        win_ok  = (beg < fin) && (fin < total);
        in_win  = win_ok && (count >= beg) && (count < fin);
    end
endmodule

// File: rtl/raster_timing_gen.sv
// Raster timing generator with counters that start at sync.
// One counter/decoder pair is built per axis. The horizontal counter
// steps on every cycle and the vertical counter steps on each horizontal
// wrap. Settings change only at the origin of a frame (the start of
// field 0 when interlace is on).
module raster_timing_gen
    import rtg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [2:0]            cfg_addr,
    input  logic [31:0]           cfg_wdata,
    input  logic [29:0]           pix_in,
    output logic                  hsync,
    output logic                  vsync,
    output logic                  de,
    output logic                  border,
    output logic                  vblank,
    output logic                  frame_start,
    output logic                  field,
    output logic [15:0]           px_x,
    output logic [15:0]           px_y,
    output logic [29:0]           pix_out
);
    localparam int N_AX = 2;

    timing_set_t live;
    logic        field_q;
    logic        boundary;
    logic        load;

    logic [CW-1:0] ax_total [N_AX];
    logic [CW-1:0] ax_sync  [N_AX];
    logic [CW-1:0] ax_beg   [N_AX];
    logic [CW-1:0] ax_fin   [N_AX];
    logic [CW-1:0] ax_cnt   [N_AX];
    logic          ax_step  [N_AX];
    logic          ax_last  [N_AX];
    logic          ax_sync_hit [N_AX];
    logic          ax_win_hit  [N_AX];

    rtg_set_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_sel (cfg_addr),
        .wr_val (cfg_wdata),
        .load   (load),
        .live   (live)
    );

    // Per-axis settings; field 1 of an interlaced scan swaps the vertical window.
    always_comb begin
        ax_total[0] = live.h_total;
        ax_sync[0]  = live.h_sync;
        ax_beg[0]   = live.h_beg;
        ax_fin[0]   = live.h_end;
        ax_total[1] = live.v_total;
        ax_sync[1]  = live.v_sync;
        ax_beg[1]   = (live.ilace && field_q) ? live.f2_beg : live.v_beg;
        ax_fin[1]   = (live.ilace && field_q) ? live.f2_end : live.v_end;
        ax_step[0]  = 1'b1;
        ax_step[1]  = ax_last[0];
    end

    for (genvar a = 0; a < N_AX; a++) begin : g_axis
        rtg_axis_counter #(.W(CW)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .step    (ax_step[a]),
            .total   (ax_total[a]),
            .count   (ax_cnt[a]),
            .at_last (ax_last[a])
        );
        rtg_axis_window #(.W(CW)) u_win (
            .count    (ax_cnt[a]),
            .total    (ax_total[a]),
            .sync_len (ax_sync[a]),
            .beg      (ax_beg[a]),
            .fin      (ax_fin[a]),
            .in_sync  (ax_sync_hit[a]),
            .in_win   (ax_win_hit[a])
        );
    end

    // Field end and shadow load point.
    always_comb begin
        boundary = ax_last[0] && ax_last[1];
        load     = boundary && (!live.ilace || field_q);
    end

    // Field toggle at every vertical wrap while interlaced.
    always_ff @(posedge clk) begin
        if (!rst_n)        field_q <= 1'b0;
        else if (boundary) field_q <= live.ilace && !field_q;
    end

    // Output decode from the counters and the working settings.
    always_comb begin
        px_x        = ax_cnt[0];
        px_y        = ax_cnt[1];
        field       = field_q;
        hsync       = ax_sync_hit[0] ^ live.h_inv;
        vsync       = ax_sync_hit[1] ^ live.v_inv;
        de          = ax_win_hit[0] && ax_win_hit[1];
        vblank      = !ax_win_hit[1];
        frame_start = (ax_cnt[0] == '0) && (ax_cnt[1] == '0);
        border      = !de && !ax_sync_hit[0] && !ax_sync_hit[1];
        if (de)          pix_out = pix_in;
        else if (border) pix_out = live.bg;
        else             pix_out = '0;
    end

    // R10
    fs_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> frame_start);
    // R5
    de_in_vwin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> !vblank);
    // R7
    field_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && live.ilace && !field_q) |=> field_q);
    // R3
    hsync_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (px_x == '0 && live.h_sync != '0) |-> (hsync != live.h_inv));
    // R8
    border_colour_chk: assert property (@(posedge clk) disable iff (!rst_n)
        border |-> (pix_out == live.bg));
endmodule

// File: tb/raster_timing_gen_tb.sv
// Scoreboard bench. A reference model steps on every clock edge and
// pushes the expected outputs into a queue. A monitor pops one entry at
// each falling edge and compares it with the design outputs.
module raster_timing_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [29:0] pix_in = 30'h15A5_A5A5;
    logic        hsync, vsync, de, border, vblank, frame_start, field;
    logic [15:0] px_x, px_y;
    logic [29:0] pix_out;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    raster_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_in(pix_in), .hsync(hsync), .vsync(vsync),
        .de(de), .border(border), .vblank(vblank), .frame_start(frame_start),
        .field(field), .px_x(px_x), .px_y(px_y), .pix_out(pix_out)
    );

    typedef struct {
        bit          in_rst;
        logic [15:0] x, y;
        logic        hs, vs, de, bd, vb, fs, fld;
        logic [29:0] pix;
    } exp_t;

    exp_t q[$];

    // reference settings: index 0 pending, 1 working
    logic [15:0] m_ht[2], m_vt[2], m_hs[2], m_vs[2], m_hb[2], m_vb[2];
    logic [15:0] m_he[2], m_ve[2], m_fb[2], m_fe[2];
    logic        m_il[2], m_hi[2], m_vi[2];
    logic [29:0] m_bg[2];
    logic [15:0] mx = 0, my = 0;
    logic        mf = 0;

    task automatic copy_set(input int d, input int s);
        m_ht[d]=m_ht[s]; m_vt[d]=m_vt[s]; m_hs[d]=m_hs[s]; m_vs[d]=m_vs[s];
        m_hb[d]=m_hb[s]; m_vb[d]=m_vb[s]; m_he[d]=m_he[s]; m_ve[d]=m_ve[s];
        m_fb[d]=m_fb[s]; m_fe[d]=m_fe[s]; m_il[d]=m_il[s]; m_hi[d]=m_hi[s];
        m_vi[d]=m_vi[s]; m_bg[d]=m_bg[s];
    endtask

    task automatic clear_sets();
        for (int i = 0; i < 2; i++) begin
            m_ht[i]=0; m_vt[i]=0; m_hs[i]=0; m_vs[i]=0; m_hb[i]=0; m_vb[i]=0;
            m_he[i]=0; m_ve[i]=0; m_fb[i]=0; m_fe[i]=0; m_il[i]=0; m_hi[i]=0;
            m_vi[i]=0; m_bg[i]=0;
        end
    endtask

    // Reference model step: the driver side of the scoreboard.
    always @(posedge clk) begin
        exp_t e;
        logic [15:0] lh, lv, vb_sel, ve_sel;
        logic hw, vw, hs_r, vs_r, ha, va;
        if (!rst_n) begin
            clear_sets(); mx = 0; my = 0; mf = 0;   // R1
        end else begin
            lh = (m_ht[1] == 0) ? 16'd0 : m_ht[1] - 16'd1;
            lv = (m_vt[1] == 0) ? 16'd0 : m_vt[1] - 16'd1;
            hw = (mx >= lh); vw = (my >= lv);
            if (hw && vw) begin                       // R9 load point
                if (m_il[1] && !mf) mf = 1;
                else begin copy_set(1, 0); mf = 0; end
            end
            if (cfg_we) begin                         // R11 map
                case (cfg_addr)
                    3'd0: begin m_ht[0]=cfg_wdata[15:0]; m_vt[0]=cfg_wdata[31:16]; end
                    3'd1: begin m_hs[0]=cfg_wdata[15:0]; m_vs[0]=cfg_wdata[31:16]; end
                    3'd2: begin m_hb[0]=cfg_wdata[15:0]; m_vb[0]=cfg_wdata[31:16]; end
                    3'd3: begin m_he[0]=cfg_wdata[15:0]; m_ve[0]=cfg_wdata[31:16]; end
                    3'd4: begin m_fe[0]=cfg_wdata[15:0]; m_fb[0]=cfg_wdata[31:16]; end
                    3'd5: begin m_il[0]=cfg_wdata[0]; m_hi[0]=cfg_wdata[1]; m_vi[0]=cfg_wdata[2]; end
                    3'd6: m_bg[0]=cfg_wdata[29:0];
                    default: ;
                endcase
            end
            if (hw) begin mx = 0; my = vw ? 16'd0 : my + 16'd1; end
            else mx = mx + 16'd1;
        end
        vb_sel = (m_il[1] && mf) ? m_fb[1] : m_vb[1];
        ve_sel = (m_il[1] && mf) ? m_fe[1] : m_ve[1];
        hs_r = mx < m_hs[1];
        vs_r = my < m_vs[1];
        ha = (m_hb[1] < m_he[1]) && (m_he[1] < m_ht[1]) && mx >= m_hb[1] && mx < m_he[1];
        va = (vb_sel < ve_sel) && (ve_sel < m_vt[1]) && my >= vb_sel && my < ve_sel;
        e.in_rst = !rst_n;
        e.x = mx; e.y = my;
        e.hs = hs_r ^ m_hi[1]; e.vs = vs_r ^ m_vi[1];
        e.de = ha && va; e.vb = !va;
        e.bd = !e.de && !hs_r && !vs_r;
        e.fs = (mx == 0) && (my == 0);
        e.fld = mf;
        e.pix = e.de ? pix_in : (e.bd ? m_bg[1] : 30'd0);
        q.push_back(e);
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: pop and compare away from the active edge.
    always @(negedge clk) begin
        if (!done && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            if (e.in_rst) begin
                chk("R1 reset px_x", 32'(px_x), 32'(e.x));
                chk("R1 reset de", 32'(de), 32'(e.de));
                chk("R1 reset frame_start", 32'(frame_start), 32'(e.fs));
            end else begin
                chk("R2/R11 px_x", 32'(px_x), 32'(e.x));
                chk("R2 px_y", 32'(px_y), 32'(e.y));
                chk("R3/R4 hsync", 32'(hsync), 32'(e.hs));
                chk("R3/R4 vsync", 32'(vsync), 32'(e.vs));
                chk("R5/R6/R9 de", 32'(de), 32'(e.de));
                chk("R10 vblank", 32'(vblank), 32'(e.vb));
                chk("R10 frame_start", 32'(frame_start), 32'(e.fs));
                chk("R7 field", 32'(field), 32'(e.fld));
                chk("R8 border", 32'(border), 32'(e.bd));
                chk("R8 pix_out", 32'(pix_out), 32'(e.pix));
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog R2 actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;                          // R1 checked during reset
        repeat (3) @(negedge clk);
        // R2 R3 R5 R11: 12x8 progressive raster
        wr(3'd0, {16'd8, 16'd12});
        wr(3'd1, {16'd1, 16'd2});
        wr(3'd2, {16'd2, 16'd4});
        wr(3'd3, {16'd6, 16'd10});
        wr(3'd6, 30'h0AB_CDEF);
        repeat (300) @(negedge clk);
        // R4 R8 R9: polarity and colour change mid-frame
        repeat (37) @(negedge clk);
        wr(3'd5, 32'd6);
        wr(3'd6, 30'h3FF_0001);
        repeat (250) @(negedge clk);
        // R6: empty horizontal window, then vertical end beyond total
        wr(3'd3, {16'd6, 16'd4});
        repeat (200) @(negedge clk);
        wr(3'd3, {16'd9, 16'd10});
        repeat (200) @(negedge clk);
        wr(3'd3, {16'd6, 16'd10});
        // R7: interlace with second-field window 3..7
        wr(3'd4, {16'd3, 16'd7});
        wr(3'd5, 32'd1);
        repeat (500) @(negedge clk);
        // R9: total changes mid-frame, then interlace off
        repeat (21) @(negedge clk);
        wr(3'd0, {16'd9, 16'd16});
        wr(3'd5, 32'd2);
        repeat (600) @(negedge clk);
        finish_run();
    end
endmodule